// File: doc/BRIEF.md
# DMA Burst Boundary Splitter

This block sits between a DMA channel's burst scheduler and the bus address phase. Each request describes one burst: a start address, a beat count, a beat width and a flag that says whether the address advances from beat to beat. The block makes sure that no bus transaction crosses an address boundary. The boundary is aligned to the size of the whole burst in bytes, which is the beat count times the beat width.

When an incrementing burst would run past the next such boundary, the block cuts it into two transactions. The first covers the beats below the boundary. The second starts exactly on the boundary and carries the remaining beats. A burst that already starts on a boundary, or that uses a fixed address, leaves as a single transaction. Both sides use a valid/ready handshake. A new request is taken only after the last transaction of the previous one has been accepted downstream.

Top module: `dbs_burst_splitter`

## Requirements
- R1: The split boundary is aligned to beats × bytes-per-beat. For example, 16 beats of 4 bytes at 0x0C000024 leave as 7 beats at 0x0C000024 and then 9 beats at 0x0C000040.
- R2: A request with `req_incr` low leaves as exactly one transaction, with the requested address and beat count, whatever the address.
- R3: An incrementing request whose address is not on the boundary leaves first as a transaction at the requested address. Its beat count is (boundary − address) / bytes-per-beat, and it does not cross the boundary.
- R4: The second transaction of a split starts at the boundary. Its beat count is the requested count minus the first transaction's count.
- R5: An incrementing request whose address is already on the boundary leaves as one transaction with the full beat count.
- R6: `req_ready` is high exactly when no transaction is pending, so no request is taken until the last transaction of the previous one is accepted. A transaction is offered (`txn_valid` high) exactly while one is pending.
- R7: While `txn_valid` is high and `txn_ready` is low, all `txn_*` outputs hold their values.
- R8: `req_size` uses the encoding 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Beat counts are the plain numbers 1, 4, 8, 16, 32, 64, 128 or 256. Both `txn_size` and `txn_incr` repeat the request's values on every transaction.
- R9: After reset, `req_ready` is high and `txn_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Start byte address |
| req_beats | input | 9 | Beat count (1 to 256) |
| req_size | input | 2 | Beat width code: 0=1B, 1=2B, 2=4B |
| req_incr | input | 1 | Address increments per beat |
| txn_valid | output | 1 | Transaction offered downstream |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_addr | output | 32 | Transaction start address |
| txn_beats | output | 9 | Transaction beat count |
| txn_size | output | 2 | Beat width code, copied from the request |
| txn_incr | output | 1 | Increment flag, copied from the request |

## Verification
The assertions assume well-formed requests. The beat count is a power of two from 1 to 256, the width code is 0 to 2, and the address is a multiple of the beat width. The no-crossing property and the sum property rely on these assumptions. The bench draws every random address already masked to the width, and draws the beat count only as a shifted one. It also keeps `req_valid` and its fields steady until the request is taken, as the handshake requires.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 9;
    localparam int SIZE_W   = 2;
    localparam int MAX_SIZE = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  beats;
    } seg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } st_e;

    typedef struct packed {
        st_e               st;
        seg_t              first;
        seg_t              second;
        logic              split;
        logic [SIZE_W-1:0] size;
        logic              incr;
        logic [LEN_W-1:0]  len;
    } issue_t;
endpackage

// File: rtl/dbs_align_calc.sv
module dbs_align_calc
    import dbs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  beats_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              incr_i,
    output logic              split_o,
    output seg_t              first_o,
    output seg_t              second_o
);
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] room;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  head_beats;

    always_comb begin
        span       = ADDR_W'(beats_i) << size_i;
        mask       = span - ADDR_W'(1);
        off        = addr_i & mask;
        base       = addr_i & ~mask;
        room       = span - off;
        head_beats = LEN_W'(room >> size_i);
        split_o    = incr_i && (off != '0);

        first_o.addr  = addr_i;
        first_o.beats = split_o ? head_beats : beats_i;

        second_o.addr  = base + span;
        second_o.beats = split_o ? (beats_i - head_beats) : '0;
    end
endmodule

// File: rtl/dbs_issue_fsm.sv
module dbs_issue_fsm
    import dbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_beats,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_incr,
    input  logic              split_i,
    input  seg_t              first_i,
    input  seg_t              second_i,
    output logic              txn_valid,
    input  logic              txn_ready,
    output logic [ADDR_W-1:0] txn_addr,
    output logic [LEN_W-1:0]  txn_beats,
    output logic [SIZE_W-1:0] txn_size,
    output logic              txn_incr
);
    localparam issue_t RESET_STATE = '{st: ST_IDLE, first: '0, second: '0,
                                       split: 1'b0, size: '0, incr: 1'b0, len: '0};

    issue_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st     = ST_FIRST;
                    s_d.first  = first_i;
                    s_d.second = second_i;
                    s_d.split  = split_i;
                    s_d.size   = req_size;
                    s_d.incr   = req_incr;
                    s_d.len    = req_beats;
                end
            end
            ST_FIRST: begin
                if (txn_ready) s_d.st = s_q.split ? ST_SECOND : ST_IDLE;
            end
            ST_SECOND: begin
                if (txn_ready) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_STATE;
        else        s_q <= s_d;
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign txn_valid = (s_q.st != ST_IDLE);
    assign txn_addr  = (s_q.st == ST_SECOND) ? s_q.second.addr  : s_q.first.addr;
    assign txn_beats = (s_q.st == ST_SECOND) ? s_q.second.beats : s_q.first.beats;
    assign txn_size  = s_q.size;
    assign txn_incr  = s_q.incr;

    // Window arithmetic used only by the checks below
    logic [ADDR_W-1:0] win_span, win_off, win_used, in_span;
    always_comb begin
        win_span = ADDR_W'(s_q.len) << s_q.size;
        win_off  = txn_addr & (win_span - ADDR_W'(1));
        win_used = ADDR_W'(txn_beats) << s_q.size;
        in_span  = ADDR_W'(req_beats) << req_size;
    end

    p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) &&
                                       $stable(txn_beats) && $stable(txn_size) &&
                                       $stable(txn_incr)));

    p_nocross_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && s_q.incr) |-> ((win_off + win_used) <= win_span));

    p_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SECOND) |-> ((s_q.first.beats + s_q.second.beats) == s_q.len));

    p_fixed_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !s_q.incr) |-> (s_q.st == ST_FIRST && !s_q.split));

    p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_incr &&
         ((req_addr & (in_span - ADDR_W'(1))) == '0)) |=> !s_q.split);

    p_second_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SECOND) |-> (win_off == '0));
endmodule

// File: rtl/dbs_burst_splitter.sv
module dbs_burst_splitter
    import dbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_beats,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_incr,
    output logic              txn_valid,
    input  logic              txn_ready,
    output logic [ADDR_W-1:0] txn_addr,
    output logic [LEN_W-1:0]  txn_beats,
    output logic [SIZE_W-1:0] txn_size,
    output logic              txn_incr
);
    logic split_w;
    seg_t first_w, second_w;

    dbs_align_calc u_calc (
        .addr_i   (req_addr),
        .beats_i  (req_beats),
        .size_i   (req_size),
        .incr_i   (req_incr),
        .split_o  (split_w),
        .first_o  (first_w),
        .second_o (second_w)
    );

    dbs_issue_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_beats (req_beats),
        .req_size  (req_size),
        .req_incr  (req_incr),
        .split_i   (split_w),
        .first_i   (first_w),
        .second_i  (second_w),
        .txn_valid (txn_valid),
        .txn_ready (txn_ready),
        .txn_addr  (txn_addr),
        .txn_beats (txn_beats),
        .txn_size  (txn_size),
        .txn_incr  (txn_incr)
    );
endmodule

// File: tb/dbs_burst_splitter_test.sv
module dbs_burst_splitter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [31:0] req_addr;
    logic [8:0]  req_beats;
    logic [1:0]  req_size;
    logic        req_incr;
    logic        txn_valid, txn_ready;
    logic [31:0] txn_addr;
    logic [8:0]  txn_beats;
    logic [1:0]  txn_size;
    logic        txn_incr;

    always #2.5 clk = ~clk;

    dbs_burst_splitter uut (.*);

    int checks = 0;
    int errors = 0;

    // pending stimulus
    longint s_addr[$]; int s_beats[$]; int s_size[$]; int s_incr[$]; string s_tag[$];
    // expected transactions
    longint e_addr[$]; int e_beats[$]; int e_size[$]; int e_incr[$]; string e_tag[$];
    string cur_tag;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic add_req(longint a, int b, int sz, int inc, string tag);
        s_addr.push_back(a); s_beats.push_back(b); s_size.push_back(sz);
        s_incr.push_back(inc); s_tag.push_back(tag);
    endtask

    task automatic push_exp(longint a, int b, int sz, int inc, string tag);
        e_addr.push_back(a & 64'hFFFF_FFFF); e_beats.push_back(b); e_size.push_back(sz);
        e_incr.push_back(inc); e_tag.push_back(tag);
    endtask

    // Reference behaviour from the requirements
    task automatic model(longint a, int b, int sz, int inc, string tag);
        longint bytes, span, off, first;
        bytes = longint'(1) << sz;
        span  = longint'(b) * bytes;
        off   = a % span;
        if (inc != 0 && off != 0) begin
            first = (span - off) / bytes;
            push_exp(a, int'(first), sz, inc, (tag != "") ? tag : "R3");
            push_exp(a - off + span, b - int'(first), sz, inc, (tag != "") ? tag : "R4");
        end else begin
            push_exp(a, b, sz, inc, (tag != "") ? tag : ((inc != 0) ? "R5" : "R2"));
        end
    endtask

    initial begin
        logic        clear_req, stalled, rf, tf;
        logic [31:0] p_addr;
        logic [8:0]  p_beats;
        logic [1:0]  p_size;
        logic        p_incr;
        int          cyc;

        // directed cases
        add_req(64'h0C00_0024, 16, 2, 1, "R1");
        add_req(64'h0C00_0040, 16, 2, 1, "R5");
        add_req(64'h0C00_0024, 16, 2, 0, "R2");
        add_req(64'h0000_1004, 256, 2, 1, "");
        add_req(64'h0000_13FC, 256, 2, 1, "");
        add_req(64'h0000_0007, 8, 0, 1, "");
        add_req(64'h0000_0006, 4, 1, 1, "");
        add_req(64'h0000_0123, 1, 0, 1, "R5");
        add_req(64'hFFFF_FFF8, 4, 2, 1, "");
        add_req(64'h0000_0202, 256, 1, 0, "R2");
        for (int i = 0; i < 400; i++) begin
            int sz, bl;
            longint a;
            sz = int'($urandom % 3);
            bl = 1 << ($urandom % 9);
            if (bl == 2) bl = 4;
            a  = longint'($urandom) & ~((longint'(1) << sz) - 1);
            add_req(a, bl, sz, int'($urandom % 4 != 0), "");
        end

        rst_n = 1'b0; req_valid = 1'b0; txn_ready = 1'b0;
        req_addr = '0; req_beats = '0; req_size = '0; req_incr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "req_ready in reset", longint'(req_ready), 1);
        chk("R9", "txn_valid in reset", longint'(txn_valid), 0);
        rst_n = 1'b1;

        clear_req = 1'b0; stalled = 1'b0; cyc = 0;
        p_addr = '0; p_beats = '0; p_size = '0; p_incr = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                break;
            end
            // compare outputs against model
            chk("R6", "req_ready", longint'(req_ready), longint'(e_addr.size() == 0));
            chk("R6", "txn_valid", longint'(txn_valid), longint'(e_addr.size() != 0));
            if (txn_valid && e_addr.size() != 0) begin
                chk(e_tag[0], "txn_addr",  longint'(txn_addr),  e_addr[0]);
                chk(e_tag[0], "txn_beats", longint'(txn_beats), longint'(e_beats[0]));
                chk("R8", "txn_size", longint'(txn_size), longint'(e_size[0]));
                chk("R8", "txn_incr", longint'(txn_incr), longint'(e_incr[0]));
            end
            if (stalled) begin
                chk("R7", "held valid", longint'(txn_valid), 1);
                chk("R7", "held addr",  longint'(txn_addr),  longint'(p_addr));
                chk("R7", "held beats", longint'(txn_beats), longint'(p_beats));
                chk("R7", "held size",  longint'(txn_size),  longint'(p_size));
                chk("R7", "held incr",  longint'(txn_incr),  longint'(p_incr));
            end
            if (clear_req) begin
                req_valid = 1'b0;
                clear_req = 1'b0;
            end
            if (s_addr.size() == 0 && !req_valid && e_addr.size() == 0) break;
            // drive next inputs
            if (!req_valid && s_addr.size() != 0 && ($urandom % 4 != 0)) begin
                req_addr  = 32'(s_addr.pop_front());
                req_beats = 9'(s_beats.pop_front());
                req_size  = 2'(s_size.pop_front());
                req_incr  = 1'(s_incr.pop_front());
                cur_tag   = s_tag.pop_front();
                req_valid = 1'b1;
            end
            txn_ready = ($urandom % 10) < 7;
            // predict what happens at the coming edge
            rf = req_valid && req_ready;
            tf = txn_valid && txn_ready;
            stalled = txn_valid && !txn_ready;
            p_addr = txn_addr; p_beats = txn_beats; p_size = txn_size; p_incr = txn_incr;
            if (tf) begin
                void'(e_addr.pop_front()); void'(e_beats.pop_front());
                void'(e_size.pop_front()); void'(e_incr.pop_front());
                void'(e_tag.pop_front());
            end
            if (rf) begin
                model(longint'(req_addr), int'(req_beats), int'(req_size),
                      int'(req_incr), cur_tag);
                clear_req = 1'b1;
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule